// File: doc/BRIEF.md
# Phase-Frequency Detector with Lead Flags

This block is a sampled digital model of a three-state phase-frequency detector. It watches a reference clock and a feedback clock, both slower than its own sample clock. It drives a charge-pump request pair: `up_o` means "speed up the oscillator" and `dn_o` means "slow it down". Each request is a pulse whose width, in sample cycles, equals the phase gap between the two input edges.

Two lead flags report when the loop has lost lock. `ref_lead_o` means the reference edges arrive first, so the oscillator is running too slow. `fb_lead_o` means the feedback edges arrive first, so the oscillator is running too fast.

The reference-side flag samples `up_o` a fixed sensitivity window of `DELAY_T` sample cycles after each reference edge. The feedback-side flag samples `dn_o` at each feedback edge. `DELAY_T` must be set wider than any pulse seen in normal locked operation. Otherwise the flags would assert while the loop is in lock.

Top module: `pfd_lock_mon`

## Requirements
- R1: While `rst_n` is low at a rising sample-clock edge, that edge clears `up_o`, `dn_o`, `ref_lead_o` and `fb_lead_o` to 0, along with the synchronizers and the reference delay line.
- R2: Each raw input passes through two synchronizing flip-flops. A raw 0-to-1 transition that is set up before sample edge n changes `up_o` or `dn_o` after edge n+2, and not before.
- R3: A detected reference rising edge sets `up_o`, and `up_o` stays 1 until `dn_o` would also become 1. A detected feedback rising edge sets `dn_o` in the same way.
- R4: Whenever both requests would be 1, both are cleared in that same update. `up_o` and `dn_o` are never 1 together. Rising edges detected in the same sample cycle produce no pulse on either output.
- R5: At each detected feedback rising edge, `fb_lead_o` takes the value `dn_o` held just before that edge was applied.
- R6: `DELAY_T` sample cycles after each detected reference rising edge, `ref_lead_o` takes the current value of `up_o`. It therefore becomes 1 exactly when the up pulse started by that edge lasted at least `DELAY_T` cycles. With equal input latency, this means the feedback edge lags the reference edge by `DELAY_T` or more sample cycles.
- R7: Each flag changes only at its own capture event and otherwise holds its value. A flag that is 1 returns to 0 at the next capture that finds its request low.
- R8: With a persistent frequency error, the matching flag is 1 for at least three quarters of the time and the opposite flag stays 0. Here a persistent error means one input clock running at least five times faster than the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, much faster than both inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_clk_i | input | 1 | Reference clock, asynchronous to `clk` |
| fb_clk_i | input | 1 | Divided oscillator feedback clock, asynchronous to `clk` |
| up_o | output | 1 | Charge-pump request to raise the oscillator frequency |
| dn_o | output | 1 | Charge-pump request to lower the oscillator frequency |
| ref_lead_o | output | 1 | Reference leads: oscillator too slow |
| fb_lead_o | output | 1 | Feedback leads: oscillator too fast |

## Verification
A wrong internal state shows up at the ports in different ways depending on where it is:

- A stuck or mis-cleared request shows on `up_o` or `dn_o` within one sample cycle of the next detected edge.
- A corrupted synchronizer stage shifts every pulse edge by a cycle within three cycles of an input transition.
- A delay line of the wrong length moves the point where `ref_lead_o` flips. This is visible only when a pulse width sits right at the `DELAY_T` boundary, which is why the widths `DELAY_T`-1 and `DELAY_T` are driven directly.
- A flag that updates outside its capture event differs from the expected value within one input period.

Random phase and frequency mixes cover these cases, together with persistent-error runs and mid-run reset.

// File: rtl/pfd_pkg.sv
// Shared types for the phase-frequency detector model.
package pfd_pkg;

    // Charge-pump request pair.
    typedef struct packed {
        logic up;
        logic dn;
    } pump_req_t;

endpackage

// File: rtl/pfd_edge_sync.sv
// Synchronizes an asynchronous slow clock into the sample domain and flags
// its rising edges. Assumes the input stays high and low for at least two
// sample cycles each. Latency: raw edge to rise_o is STAGES sample edges.
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the raw input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_i};
        end
    end

    // Remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise_o = sync_q[STAGES-1] & ~prev_q;

    // A detected edge cannot be followed by another on the next cycle.
    p_single_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/pfd_tap_delay.sv
// Delays a single-cycle pulse by DEPTH sample cycles. Assumes pulses come
// from an edge detector; overlapping pulses are simply shifted along.
module pfd_tap_delay #(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_i,
    output logic pulse_o
);
    logic [DEPTH-1:0] tap_q;

    generate
        if (DEPTH == 1) begin : g_one
            // Single register stage.
            always_ff @(posedge clk) begin
                if (!rst_n) tap_q <= '0;
                else        tap_q <= pulse_i;
            end
        end else begin : g_many
            // Shift register of DEPTH stages.
            always_ff @(posedge clk) begin
                if (!rst_n) tap_q <= '0;
                else        tap_q <= {tap_q[DEPTH-2:0], pulse_i};
            end
        end
    endgenerate

    assign pulse_o = tap_q[DEPTH-1];

endmodule

// File: rtl/pfd_core.sv
// Three-state request logic: reference edges set UP, feedback edges set DN,
// and the state where both would be set resets to idle in the same cycle.
// Assumes edge inputs are single-cycle pulses in the sample domain.
module pfd_core
    import pfd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ref_rise_i,
    input  logic      fb_rise_i,
    output pump_req_t req_o
);
    pump_req_t req_q;
    pump_req_t req_d;

    // Set on edges, collapse to idle when both sides are requested.
    always_comb begin
        req_d.up = req_q.up | ref_rise_i;
        req_d.dn = req_q.dn | fb_rise_i;
        if (req_d.up && req_d.dn) begin
            req_d = '0;
        end
    end

    // Register the request state.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    assign req_o = req_q;

    // A lone reference edge with no pending DN raises UP.
    p_up_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_rise_i && !fb_rise_i && !req_q.dn) |=> req_q.up);

    // A feedback edge while UP is pending ends the pulse without a DN pulse.
    p_up_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q.up && fb_rise_i) |=> (!req_q.up && !req_q.dn));

    // UP holds without a feedback edge.
    p_up_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q.up && !fb_rise_i) |=> req_q.up);

endmodule

// File: rtl/pfd_lock_mon.sv
// Sampled phase-frequency detector with two lead flags. The reference-side
// flag samples UP DELAY_T cycles after each reference edge; the feedback-side
// flag samples DN at each feedback edge. Assumes clk is several times faster
// than both inputs and DELAY_T exceeds locked pulse widths.
module pfd_lock_mon
    import pfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DELAY_T     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_clk_i,
    input  logic fb_clk_i,
    output logic up_o,
    output logic dn_o,
    output logic ref_lead_o,
    output logic fb_lead_o
);
    logic      ref_rise;
    logic      fb_rise;
    logic      ref_late;
    pump_req_t req;
    logic      ref_lead_q;
    logic      fb_lead_q;

    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk(clk), .rst_n(rst_n), .async_i(ref_clk_i), .rise_o(ref_rise));

    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_fb_sync (
        .clk(clk), .rst_n(rst_n), .async_i(fb_clk_i), .rise_o(fb_rise));

    pfd_core u_core (
        .clk(clk), .rst_n(rst_n), .ref_rise_i(ref_rise), .fb_rise_i(fb_rise),
        .req_o(req));

    pfd_tap_delay #(.DEPTH(DELAY_T)) u_ref_delay (
        .clk(clk), .rst_n(rst_n), .pulse_i(ref_rise), .pulse_o(ref_late));

    // Capture DN at each feedback edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       fb_lead_q <= 1'b0;
        else if (fb_rise) fb_lead_q <= req.dn;
    end

    // Capture UP one sensitivity window after each reference edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        ref_lead_q <= 1'b0;
        else if (ref_late) ref_lead_q <= req.up;
    end

    assign up_o       = req.up;
    assign dn_o       = req.dn;
    assign ref_lead_o = ref_lead_q;
    assign fb_lead_o  = fb_lead_q;

    // Requests are mutually exclusive.
    p_req_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_o && dn_o));

    // Feedback flag follows the pre-edge DN value.
    p_fb_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fb_rise |=> (fb_lead_o == $past(dn_o)));

    // Reference flag follows UP at the delayed capture.
    p_ref_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ref_late |=> (ref_lead_o == $past(up_o)));

    // Flags are stable between their capture events.
    p_fb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fb_rise |=> $stable(fb_lead_o));

    p_ref_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_late |=> $stable(ref_lead_o));

endmodule

// File: tb/pfd_lock_mon_bench.sv
module pfd_lock_mon_bench;
    localparam int T = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0;
    logic fb_in = 1'b0;
    logic up, dn, ref_lead, fb_lead;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;
    bit seen_req = 1'b0;

    always #5 clk = ~clk;

    pfd_lock_mon #(.SYNC_STAGES(2), .DELAY_T(T)) u_pfd_lock_mon (
        .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_in), .fb_clk_i(fb_in),
        .up_o(up), .dn_o(dn), .ref_lead_o(ref_lead), .fb_lead_o(fb_lead));

    // Expected-value model built from R1..R7: two-cycle synchronizer plus
    // edge register (R2), set/collapse requests (R3, R4), captures (R5, R6).
    logic [2:0]   m_rs = '0, m_fs = '0;
    logic         m_up = 1'b0, m_dn = 1'b0, m_rl = 1'b0, m_fl = 1'b0;
    logic [T-1:0] m_q = '0;

    function automatic logic rise_of(input logic [2:0] h);
        return h[1] & ~h[2];
    endfunction

    always @(posedge clk) begin
        logic rr, fr, nu, nd;
        if (!rst_n) begin
            m_rs = '0; m_fs = '0; m_up = 0; m_dn = 0;
            m_rl = 0; m_fl = 0; m_q = '0;
        end else begin
            rr = rise_of(m_rs);
            fr = rise_of(m_fs);
            if (fr) m_fl = m_dn;
            if (m_q[T-1]) m_rl = m_up;
            nu = m_up | rr;
            nd = m_dn | fr;
            if (nu && nd) begin nu = 0; nd = 0; end
            m_up = nu; m_dn = nd;
            m_q  = {m_q[T-2:0], rr};
            m_rs = {m_rs[1:0], ref_in};
            m_fs = {m_fs[1:0], fb_in};
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the clock edge.
    bit model_on = 1'b0;
    always @(negedge clk) begin
        if (up || dn) seen_req = 1'b1;
        if (model_on) begin
            chk("R3 up_o", up, m_up);
            chk("R3 dn_o", dn, m_dn);
            chk("R6 ref_lead_o", ref_lead, m_rl);
            chk("R5 fb_lead_o", fb_lead, m_fl);
        end
    end

    task automatic run_clocks(input int rh, input int fh, input int fo, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ref_in = ((i / rh) % 2) == 1;
            fb_in  = (((i + fo) / fh) % 2) == 1;
        end
    endtask

    // Persistent frequency error: count flag-high cycles in a late window.
    task automatic error_window(input int rh, input int fh, input bit ref_side);
        int hi = 0, opp = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            ref_in = ((i / rh) % 2) == 1;
            fb_in  = ((i / fh) % 2) == 1;
            if (i >= 1000) begin
                if (ref_side ? ref_lead : fb_lead) hi++;
                if (ref_side ? fb_lead : ref_lead) opp++;
            end
        end
        chk("R8 matching flag mostly high", hi >= 1500, 1'b1);
        chk("R8 opposite flag stays low", opp == 0, 1'b1);
    endtask

    task automatic idle(input int n);
        @(negedge clk); ref_in = 0; fb_in = 0;
        repeat (n) @(negedge clk);
    endtask

    // Reference edge, then feedback edge k cycles later.
    task automatic edge_pair(input int k, input string req, input logic exp_flag);
        @(negedge clk);
        ref_in = 1;
        if (k == 0) fb_in = 1;
        else begin
            repeat (k) @(negedge clk);
            fb_in = 1;
        end
        repeat (T + 6) @(negedge clk);
        chk(req, ref_lead, exp_flag);
        ref_in = 0; fb_in = 0;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 up_o in reset", up, 1'b0);
        chk("R1 dn_o in reset", dn, 1'b0);
        chk("R1 ref_lead_o in reset", ref_lead, 1'b0);
        chk("R1 fb_lead_o in reset", fb_lead, 1'b0);
        rst_n = 1;
        model_on = 1;
        repeat (4) @(negedge clk);

        // R2: latency of a raw reference edge to up_o.
        ref_in = 1;
        @(negedge clk); chk("R2 no change after 1 edge", up, 1'b0);
        @(negedge clk); chk("R2 no change after 2 edges", up, 1'b0);
        @(negedge clk); chk("R2 up after 3 edges", up, 1'b1);
        fb_in = 1;
        repeat (4) @(negedge clk);
        chk("R4 up cleared by feedback edge", up, 1'b0);
        chk("R4 no dn pulse", dn, 1'b0);
        idle(8);

        // R4: simultaneous edges give no pulse.
        seen_req = 0;
        edge_pair(0, "R4 simultaneous edges flag", 1'b0);
        chk("R4 simultaneous edges no request", seen_req, 1'b0);

        // R6 boundary and R7 recovery.
        edge_pair(T - 1, "R6 width T-1 leaves flag low", 1'b0);
        edge_pair(T, "R6 width T sets flag", 1'b1);
        edge_pair(2, "R7 short pulse clears flag", 1'b0);
        edge_pair(T + 3, "R6 long pulse sets flag", 1'b1);
        idle(40);
        chk("R7 flag holds with no capture", ref_lead, 1'b1);

        // R5: two feedback edges with no reference edge between.
        fb_in = 1; repeat (4) @(negedge clk);
        fb_in = 0; repeat (4) @(negedge clk);
        fb_in = 1; repeat (4) @(negedge clk);
        chk("R5 dn held across feedback edge", fb_lead, 1'b1);
        idle(8);
        ref_in = 1; repeat (4) @(negedge clk);
        ref_in = 0; repeat (4) @(negedge clk);
        fb_in = 1; repeat (4) @(negedge clk);
        chk("R7 feedback flag clears", fb_lead, 1'b0);
        idle(8);

        // R8: persistent frequency errors in both directions.
        error_window(10, 100, 1'b1);
        error_window(100, 10, 1'b0);
        idle(20);

        // Random phase and frequency mixes.
        for (int s = 0; s < 10; s++) begin
            int rh = $urandom_range(3, 40);
            int fh = (s % 3 == 0) ? rh : $urandom_range(3, 40);
            int fo = $urandom_range(0, 2 * fh - 1);
            run_clocks(rh, fh, fo, 1500);
        end

        // R1: reset in the middle of activity.
        run_clocks(5, 40, 0, 300);
        @(negedge clk); rst_n = 0;
        @(negedge clk);
        chk("R1 up_o after mid-run reset", up, 1'b0);
        chk("R1 dn_o after mid-run reset", dn, 1'b0);
        chk("R1 ref_lead_o after mid-run reset", ref_lead, 1'b0);
        chk("R1 fb_lead_o after mid-run reset", fb_lead, 1'b0);
        rst_n = 1;
        run_clocks(7, 9, 3, 500);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(10 * 150000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule